// File: doc/BRIEF.md
# Wakeup Interrupt Sense Normalizer

This block stands between a set of external wakeup interrupt lines and an interrupt controller that only understands rising-edge and active-high requests. Every line has its own three-bit sense code and its own enable bit. After a two-stage synchronizer, each line is turned into what the controller expects. Active-low levels are inverted. Falling, rising and dual edges all become single-cycle high pulses. Lines that are disabled, or that hold an unknown sense code, stay low.

Software uses a word-addressed register port with a combinational read path. Enable bits are packed 32 to a word. Each line also has one configuration word. A configuration write blanks edge detection on that line for the cycle of the write. As a result, retyping a line can never produce a pulse by itself.

Top module: `wake_sense_norm`

## Requirements
- R1: After reset every enable bit reads 0, every sense code reads 4 (binary 100, active-high level), and every output is low.
- R2: Enable word k sits at byte address 0x10 + 4k. Bit b of that word is the enable of line 32k + b. A read returns the bits last written, and reads 0 for bit positions beyond the last line.
- R3: The configuration word of line p sits at byte address 0x110 + 4p. Its bits [2:0] hold the sense code last written, and the upper bits read 0.
- R4: A line whose enable bit is 0 drives its output low, whatever its input and code.
- R5: Code 4 (100, active-high level) gives an output equal to the input. A change at the input shows at the output after the third rising clock edge that follows it.
- R6: Code 0 (000, active-low level) gives an output equal to the inverted input, with the same latency as R5.
- R7: Code 6 (110, rising edge) gives a one-cycle high pulse for each low-to-high input transition and nothing for a high-to-low one.
- R8: Code 2 (010, falling edge) gives a one-cycle high pulse for each high-to-low input transition and nothing for a low-to-high one.
- R9: Code 7 (111, dual edge) gives a one-cycle high pulse for every input transition, including transitions on consecutive cycles.
- R10: Codes 1, 3 and 5 keep the output low.
- R11: A configuration write to a line produces no edge pulse on that line. An input transition whose detection falls in the cycle of such a write is dropped, and changing the code while the input is steady never makes a pulse.
- R12: A write to an address that is unaligned, or that is outside the enable words and configuration words, changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NPIN | Raw wakeup interrupt lines |
| irq_out | output | NPIN | Normalized requests to the downstream controller |

## Verification
Two events can land in the same cycle: an input edge reaches the detection stage, and software writes that line's configuration word. The bench provokes this by raising two rising-edge lines together and then timing a configuration write to one of them so that its clock edge is the one where the transition is detected. It then expects a pulse on the untouched line and silence on the written one, in both the detection cycle and the cycle after it. Code changes made while the input is held steady are checked the same way, by confirming that no pulse appears.

// File: rtl/wake_sense_norm.sv
module wake_sense_norm #(
  parameter int NPIN   = 40,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   irq_in,
  output logic [NPIN-1:0]   irq_out
);
  localparam int NBANK = (NPIN + 31) / 32;
  localparam logic [ADDR_W-1:0] EN_BASE  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'('h110);
  localparam logic [ADDR_W-1:0] EN_SPAN  = ADDR_W'(4 * NBANK);
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(4 * NPIN);
  localparam logic [2:0] SN_LOW = 3'b000, SN_FALL = 3'b010, SN_HIGH = 3'b100,
                         SN_RISE = 3'b110, SN_DUAL = 3'b111;

  logic [NPIN-1:0] sy1, sy2, prv, prv_eff, en, cfg_hit;
  logic [2:0]      code [NPIN];

  wire              aligned = (bus_addr[1:0] == 2'b00);
  wire [ADDR_W-1:0] en_off  = bus_addr - EN_BASE;
  wire [ADDR_W-1:0] cfg_off = bus_addr - CFG_BASE;
  wire              en_sel  = aligned && (bus_addr >= EN_BASE) && (en_off < EN_SPAN);
  wire              cfg_sel = aligned && (bus_addr >= CFG_BASE) && (cfg_off < CFG_SPAN);
  wire [ADDR_W-3:0] en_idx  = en_off[ADDR_W-1:2];
  wire [ADDR_W-3:0] cfg_idx = cfg_off[ADDR_W-1:2];

  function automatic logic sense(input logic [2:0] c, input logic cur, input logic old);
    case (c)
      SN_LOW:  return ~cur;
      SN_FALL: return old & ~cur;
      SN_HIGH: return cur;
      SN_RISE: return cur & ~old;
      SN_DUAL: return cur ^ old;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      cfg_hit[p] = bus_wen && cfg_sel && (cfg_idx == (ADDR_W-2)'(p));
      prv_eff[p] = cfg_hit[p] ? sy2[p] : prv[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
    end else begin
      sy1 <= irq_in;
      sy2 <= sy1;
      prv <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      irq_out <= '0;
      for (int p = 0; p < NPIN; p++) code[p] <= SN_HIGH;
    end else begin
      for (int p = 0; p < NPIN; p++) begin
        irq_out[p] <= en[p] & sense(code[p], sy2[p], prv_eff[p]);
        if (cfg_hit[p]) code[p] <= bus_wdata[2:0];
        if (bus_wen && en_sel && en_idx == (ADDR_W-2)'(p / 32)) en[p] <= bus_wdata[p % 32];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (en_sel && en_idx == (ADDR_W-2)'(p / 32)) bus_rdata[p % 32] = en[p];
      if (cfg_sel && cfg_idx == (ADDR_W-2)'(p)) bus_rdata[2:0] = code[p];
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_chk
    p_disabled_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en[g]) |-> !irq_out[g]);
    p_undef_code_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(code[g] == 3'b001 || code[g] == 3'b011 || code[g] == 3'b101) |-> !irq_out[g]);
    p_cfg_write_no_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_hit[g] && (code[g] == SN_RISE || code[g] == SN_FALL || code[g] == SN_DUAL))
      |-> !irq_out[g]);
    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en[g] && code[g] == SN_HIGH) |-> irq_out[g] == $past(sy2[g]));
    p_rise_needs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(code[g] == SN_RISE) && irq_out[g] |-> $past(sy2[g] && !prv[g]));
  end
endmodule

// File: tb/sim_wake_sense_norm.sv
module sim_wake_sense_norm;
  localparam int NPIN = 40;
  localparam int ADDR_W = 12;

  logic clk = 0, rst_n = 0, bus_wen = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPIN-1:0] irq_in = '0, irq_out;

  int checks = 0, failures = 0;
  logic [NPIN-1:0] hv [0:4];
  logic [NPIN-1:0] en_mask;

  wake_sense_norm #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wen = 1;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    bus_addr = ADDR_W'(a);
    #1;
    chk(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp));
  endtask

  function automatic logic model(input int c, input logic cur, input logic old);
    case (c)
      0: return !cur;
      2: return old && !cur;
      4: return cur;
      6: return cur && !old;
      7: return cur != old;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NPIN-1:0] pat(input int t);
    logic [NPIN-1:0] v;
    for (int p = 0; p < NPIN; p++)
      v[p] = (p % 4 == 3) ? 1'((t + p) % 2) : (((t * 7 + p * 3 + t * p) % 5) < 2);
    return v;
  endfunction

  task automatic step(input logic [NPIN-1:0] v, input int c, input bit do_chk, input string req);
    @(negedge clk);
    if (do_chk) begin
      logic [NPIN-1:0] e;
      for (int p = 0; p < NPIN; p++) e[p] = en_mask[p] && model(c, hv[2][p], hv[3][p]);
      chk(irq_out == e, req, 64'(irq_out), 64'(e));
    end
    for (int k = 4; k > 0; k--) hv[k] = hv[k-1];
    hv[0] = v;
    irq_in = v;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string rq;
    logic [NPIN-1:0] s;
    for (int k = 0; k < 5; k++) hv[k] = '0;
    en_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq_out == '0, "R1 outputs", 64'(irq_out), 64'd0);
    rd_chk('h10, 32'h0, "R1 enable0");
    rd_chk('h14, 32'h0, "R1 enable1");
    for (int p = 0; p < NPIN; p += 13) rd_chk('h110 + 4 * p, 32'h4, "R1 code");
    rd_chk('h110 + 4 * (NPIN - 1), 32'h4, "R1 code last");

    // R2 enable mapping and read-back
    wr('h10, 32'hF7FF_FFDF);
    wr('h14, 32'hFFFF_FFBF);
    rd_chk('h10, 32'hF7FF_FFDF, "R2 enable word0");
    rd_chk('h14, 32'h0000_00BF, "R2 enable word1 upper zero");
    en_mask = {8'hBF, 32'hF7FF_FFDF};

    // R3 config word storage
    wr('h110 + 4 * 17, 32'hFFFF_FFF5);
    rd_chk('h110 + 4 * 17, 32'h5, "R3 code bits");
    wr('h110 + 4 * 17, 32'h4);
    rd_chk('h110 + 4 * 17, 32'h4, "R3 code rewrite");

    // R12 unmapped accesses
    wr('h0C, 32'hFFFF_FFFF);
    rd_chk('h0C, 32'h0, "R12 below banks");
    rd_chk('h18, 32'h0, "R12 absent bank");
    wr('h111, 32'h0);
    rd_chk('h110, 32'h4, "R12 unaligned write ignored");
    rd_chk('h111, 32'h0, "R12 unaligned read");
    wr('h110 + 4 * NPIN, 32'h6);
    rd_chk('h110 + 4 * NPIN, 32'h0, "R12 beyond last line");
    rd_chk('h10, 32'hF7FF_FFDF, "R12 enables intact");

    // Sweep all codes over varied input patterns (R4..R10)
    s = pat(1000);
    for (int c = 0; c < 8; c++) begin
      case (c)
        0: rq = "R6 active-low";   2: rq = "R8 falling";
        4: rq = "R5 active-high";  6: rq = "R7 rising";
        7: rq = "R9 dual";         default: rq = "R10 undefined code";
      endcase
      for (int k = 0; k < 5; k++) step(s, c == 0 ? 0 : c - 1, 0, rq);
      for (int p = 0; p < NPIN; p++) wr('h110 + 4 * p, 32'(c));
      step(s, c, 0, rq);
      step(s, c, 0, rq);
      for (int k = 0; k < 4; k++) step(s, c, 1, rq);
      for (int t = 0; t < 24; t++) step(pat(t + 8 * c), c, 1, rq);
      for (int k = 0; k < 4; k++) step(s, c, 1, rq);
    end
    // R4 disabled lines confirmed low at the ports: check a disabled pin under level-low with input low
    step('0, 7, 0, "R4");
    wr('h110 + 4 * 5, 32'h0);
    for (int k = 0; k < 4; k++) step('0, 7, 0, "R4");
    chk(irq_out[5] == 1'b0, "R4 disabled pin low", 64'(irq_out[5]), 64'd0);
    chk(irq_out[4] == 1'b0, "R4 dual pin idle", 64'(irq_out[4]), 64'd0);

    // R11 configuration write coinciding with edge detection
    wr('h110 + 4 * 0, 32'h6);
    wr('h110 + 4 * 1, 32'h6);
    for (int k = 0; k < 5; k++) step('0, 7, 0, "R11");
    @(negedge clk); irq_in = 40'h3;
    @(negedge clk);
    @(negedge clk); bus_addr = ADDR_W'('h110); bus_wdata = 32'h6; bus_wen = 1;
    @(negedge clk); bus_wen = 0;
    chk(irq_out[0] == 1'b0, "R11 written line dropped", 64'(irq_out[0]), 64'd0);
    chk(irq_out[1] == 1'b1, "R11 control line pulses", 64'(irq_out[1]), 64'd1);
    @(negedge clk);
    chk(irq_out[1:0] == 2'b00, "R11 after window", 64'(irq_out[1:0]), 64'd0);
    // R11 steady input, code changed repeatedly: no pulse
    wr('h110 + 4 * 1, 32'h2);
    chk(irq_out[1] == 1'b0, "R11 retype to falling", 64'(irq_out[1]), 64'd0);
    wr('h110 + 4 * 1, 32'h7);
    chk(irq_out[1] == 1'b0, "R11 retype to dual", 64'(irq_out[1]), 64'd0);
    wr('h110 + 4 * 1, 32'h6);
    @(negedge clk);
    chk(irq_out[1] == 1'b0, "R11 retype back to rising", 64'(irq_out[1]), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule